// File: doc/BRIEF.md
# VPS Line Biphase Decoder and Page-Row Packer

This block takes the half-bit samples of the VPS data line and turns each pair of half-bits into one data bit using the biphase rule. A cell whose two halves break that rule is marked as an error. The decoded bits are grouped into 4-bit nibbles, most significant bit first. Each nibble that belongs to a stored word goes to a fixed row of a teletext-style page memory as a 5-bit entry: four data bits plus one error bit. The write port is plain and synchronous: row, column, data and a one-cycle strobe.

The surrounding logic supplies the current video line number, a pulse when the data field starts (after the start code), a pulse at the end of the line, and a capture enable. The block corrects nothing. What is written is exactly what was decoded on that line, so any voting across several receptions belongs to software reading the memory. The columns are chosen so that the programme-label words sit in the same columns as the matching Hamming-decoded broadcast-packet data.

Top module: `vps_row_packer`

## Requirements
- R1: Capture happens only while `line_num` equals 16 and `capture_en` is high. A `start_det` pulse under those conditions arms the block. Half-bits on any other line, or while `capture_en` is low, cause no write.
- R2: A valid cell decodes as follows: half-bits "1 then 0" give 1, and "0 then 1" give 0.
- R3: A cell with equal halves ("00" or "11") decodes to 0 and sets the error flag of the nibble that contains it.
- R4: `mem_data[3:0]` holds the nibble with the first-received bit in bit 3. `mem_data[4]` is the OR of the error flags of its four cells.
- R5: Every write targets row 25.
- R6: The first bits after `start_det` form word 3, and the words follow in order. Words 11 to 14 go to columns 12 to 19: each word's high nibble at the even column and its low nibble at the next one.
- R7: Word 15 goes to columns 20 and 21, and word 4 goes to columns 22 and 23 (high nibble first). Nibbles of all other words are decoded but never written, so a full line makes exactly 12 writes.
- R8: `mem_we` is a single-cycle pulse. It rises in the cycle after the clock edge that accepts the last half-bit of a stored nibble, and occurs once per such nibble.
- R9: `line_end` discards any partial nibble and half-cell, and disarms capture. A line cut short issues no write for its unfinished nibble, and the next line decodes from a clean cell boundary.
- R10: Each reception overwrites the entries with the newly decoded values, with no combination with earlier lines.
- R11: Synchronous active-high `rst` clears the bit counter, the nibble shift register, the pending error flag, the cell phase and the armed state. No write follows until a new `start_det`.
- R12: Half-bits after the 104th decoded bit (the end of word 15) are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| capture_en | input | 1 | Enables VPS capture |
| line_num | input | 9 | Current video line number |
| start_det | input | 1 | Pulse: the data field begins with the next half-bit |
| line_end | input | 1 | Pulse: the line has ended |
| half_vld | input | 1 | A half-bit sample is present |
| half_bit | input | 1 | Half-bit sample value |
| mem_we | output | 1 | Page-memory write strobe |
| mem_row | output | 5 | Write row address |
| mem_col | output | 6 | Write column address |
| mem_data | output | 5 | Error bit (4) and nibble (3:0) |

## Verification
The assertions watch every cycle for the following:
- the strobe lasts a single cycle;
- the row is always 25;
- the column stays inside 12 to 23;
- a write comes only from a half-bit accepted on line 16;
- a write never follows a line end;
- nothing is accepted while capture is disabled;
- every completed stored nibble turns into a strobe.

Only the bench's scenarios can show the actual bit values and the word-to-column layout. The same goes for the propagation of the error flags from "00" and "11" cells, for the discarding of a truncated line, for the ignoring of overlong lines, and for the overwriting of entries by a second reception.

// File: rtl/vps_pkg.sv
package vps_pkg;

  localparam int unsigned NIB_W   = 4;
  localparam int unsigned ENTRY_W = NIB_W + 1;

  typedef struct packed {
    logic err;
    logic val;
  } cell_t;

  // Biphase rule: first half high and second low is a 1, the reverse is a 0.
  // Equal halves are illegal and decode to 0 with the error set.
  function automatic cell_t biphase_decode(logic first_half, logic second_half);
    cell_t c;
    c.err = (first_half == second_half);
    c.val = first_half & ~second_half;
    return c;
  endfunction

endpackage

// File: rtl/vps_biphase_cell.sv
module vps_biphase_cell
  import vps_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic flush,
  input  logic take,
  input  logic half,
  output logic cell_vld,
  output logic cell_bit,
  output logic cell_err
);

  logic  phase_q;
  logic  first_q;
  cell_t dec;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      phase_q <= 1'b0;
      first_q <= 1'b0;
    end else if (take) begin
      phase_q <= ~phase_q;
      if (!phase_q) first_q <= half;
    end
  end

  assign dec      = biphase_decode(first_q, half);
  assign cell_vld = take & phase_q;
  assign cell_bit = dec.val;
  assign cell_err = dec.err;

endmodule

// File: rtl/vps_nibble_acc.sv
module vps_nibble_acc
  import vps_pkg::*;
#(
  parameter int unsigned NBITS      = 104,
  parameter int unsigned FIRST_WORD = 3,
  parameter int unsigned WORD_W     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              cell_vld,
  input  logic              cell_bit,
  input  logic              cell_err,
  output logic              nib_done,
  output logic [NIB_W-1:0]  nib_val,
  output logic              nib_err,
  output logic [WORD_W-1:0] nib_word,
  output logic              nib_lo,
  output logic              full
);

  localparam int unsigned CNT_W = $clog2(NBITS + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [NIB_W-2:0] sh_q;
  logic             err_q;

  assign full     = (cnt_q == CNT_W'(NBITS));
  assign nib_done = cell_vld & (cnt_q[1:0] == 2'b11);
  assign nib_val  = {sh_q, cell_bit};
  assign nib_err  = err_q | cell_err;
  assign nib_word = WORD_W'(FIRST_WORD) + WORD_W'(cnt_q >> 3);
  assign nib_lo   = cnt_q[2];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      cnt_q <= '0;
      sh_q  <= '0;
      err_q <= 1'b0;
    end else if (cell_vld) begin
      cnt_q <= cnt_q + 1'b1;
      sh_q  <= {sh_q[NIB_W-3:0], cell_bit};
      err_q <= nib_done ? 1'b0 : (err_q | cell_err);
    end
  end

endmodule

// File: rtl/vps_col_map.sv
module vps_col_map #(
  parameter int unsigned WORD_W     = 4,
  parameter int unsigned COL_W      = 6,
  parameter int unsigned PROG_WORD  = 11,
  parameter int unsigned PROG_WORDS = 4,
  parameter int unsigned PROG_COL   = 12,
  parameter int unsigned RSV_WORD   = 15,
  parameter int unsigned RSV_COL    = 20,
  parameter int unsigned PSI_WORD   = 4,
  parameter int unsigned PSI_COL    = 22
) (
  input  logic [WORD_W-1:0] word,
  input  logic              lo,
  output logic              hit,
  output logic [COL_W-1:0]  col
);

  int unsigned w;

  always_comb begin
    w   = 32'(word);
    hit = 1'b0;
    col = '0;
    if (w >= PROG_WORD && w < PROG_WORD + PROG_WORDS) begin
      hit = 1'b1;
      col = COL_W'(PROG_COL + 2 * (w - PROG_WORD) + 32'(lo));
    end else if (w == RSV_WORD) begin
      hit = 1'b1;
      col = COL_W'(RSV_COL + 32'(lo));
    end else if (w == PSI_WORD) begin
      hit = 1'b1;
      col = COL_W'(PSI_COL + 32'(lo));
    end
  end

endmodule

// File: rtl/vps_row_packer.sv
module vps_row_packer
  import vps_pkg::*;
#(
  parameter int unsigned LINE_W     = 9,
  parameter int unsigned VPS_LINE   = 16,
  parameter int unsigned ROW        = 25,
  parameter int unsigned ROW_W      = 5,
  parameter int unsigned COL_W      = 6,
  parameter int unsigned FIRST_WORD = 3,
  parameter int unsigned LAST_WORD  = 15,
  parameter int unsigned PROG_WORD  = 11,
  parameter int unsigned PROG_WORDS = 4,
  parameter int unsigned PROG_COL   = 12,
  parameter int unsigned RSV_WORD   = 15,
  parameter int unsigned RSV_COL    = 20,
  parameter int unsigned PSI_WORD   = 4,
  parameter int unsigned PSI_COL    = 22
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               capture_en,
  input  logic [LINE_W-1:0]  line_num,
  input  logic               start_det,
  input  logic               line_end,
  input  logic               half_vld,
  input  logic               half_bit,
  output logic               mem_we,
  output logic [ROW_W-1:0]   mem_row,
  output logic [COL_W-1:0]   mem_col,
  output logic [ENTRY_W-1:0] mem_data
);

  localparam int unsigned NBITS  = (LAST_WORD - FIRST_WORD + 1) * 8;
  localparam int unsigned WORD_W = $clog2(LAST_WORD + 1);

  // Named internal events, used by the checker.
  logic line_ok, start_ok, flush, take, armed_q, wr_fire;

  logic              cell_vld, cell_bit, cell_err;
  logic              nib_done, nib_err, nib_lo, full, hit;
  logic [NIB_W-1:0]  nib_val;
  logic [WORD_W-1:0] nib_word;
  logic [COL_W-1:0]  col;

  assign line_ok  = (line_num == LINE_W'(VPS_LINE));
  assign start_ok = start_det & capture_en & line_ok;
  assign flush    = line_end | start_ok;
  assign take     = armed_q & capture_en & line_ok & half_vld & ~full & ~flush;

  always_ff @(posedge clk) begin
    if (rst)           armed_q <= 1'b0;
    else if (line_end) armed_q <= 1'b0;
    else if (start_ok) armed_q <= 1'b1;
  end

  vps_biphase_cell u_cell (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .take     (take),
    .half     (half_bit),
    .cell_vld (cell_vld),
    .cell_bit (cell_bit),
    .cell_err (cell_err)
  );

  vps_nibble_acc #(
    .NBITS      (NBITS),
    .FIRST_WORD (FIRST_WORD),
    .WORD_W     (WORD_W)
  ) u_acc (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .cell_vld (cell_vld),
    .cell_bit (cell_bit),
    .cell_err (cell_err),
    .nib_done (nib_done),
    .nib_val  (nib_val),
    .nib_err  (nib_err),
    .nib_word (nib_word),
    .nib_lo   (nib_lo),
    .full     (full)
  );

  vps_col_map #(
    .WORD_W     (WORD_W),
    .COL_W      (COL_W),
    .PROG_WORD  (PROG_WORD),
    .PROG_WORDS (PROG_WORDS),
    .PROG_COL   (PROG_COL),
    .RSV_WORD   (RSV_WORD),
    .RSV_COL    (RSV_COL),
    .PSI_WORD   (PSI_WORD),
    .PSI_COL    (PSI_COL)
  ) u_map (
    .word (nib_word),
    .lo   (nib_lo),
    .hit  (hit),
    .col  (col)
  );

  assign wr_fire = nib_done & hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we   <= 1'b0;
      mem_col  <= '0;
      mem_data <= '0;
    end else begin
      mem_we <= wr_fire;
      if (wr_fire) begin
        mem_col  <= col;
        mem_data <= {nib_err, nib_val};
      end
    end
  end

  assign mem_row = ROW_W'(ROW);

endmodule

// File: rtl/vps_row_packer_chk.sv
module vps_row_packer_chk #(
  parameter int unsigned LINE_W   = 9,
  parameter int unsigned VPS_LINE = 16,
  parameter int unsigned ROW      = 25,
  parameter int unsigned ROW_W    = 5,
  parameter int unsigned COL_W    = 6,
  parameter int unsigned COL_LO   = 12,
  parameter int unsigned COL_HI   = 23
) (
  input logic              clk,
  input logic              rst,
  input logic              capture_en,
  input logic [LINE_W-1:0] line_num,
  input logic              line_end,
  input logic              take,
  input logic              wr_fire,
  input logic              mem_we,
  input logic [ROW_W-1:0]  mem_row,
  input logic [COL_W-1:0]  mem_col
);

  // R8
  we_single_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  // R8
  strobe_follow_chk: assert property (@(posedge clk) disable iff (rst)
    wr_fire |=> mem_we);

  // R5
  row_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_row == ROW_W'(ROW));

  // R7
  col_range_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_col >= COL_W'(COL_LO) && mem_col <= COL_W'(COL_HI)));

  // R1
  line_gate_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(line_num) == LINE_W'(VPS_LINE));

  // R1
  en_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !capture_en |-> !take);

  // R9
  flush_chk: assert property (@(posedge clk) disable iff (rst)
    line_end |=> !mem_we);

endmodule

bind vps_row_packer vps_row_packer_chk #(
  .LINE_W   (LINE_W),
  .VPS_LINE (VPS_LINE),
  .ROW      (ROW),
  .ROW_W    (ROW_W),
  .COL_W    (COL_W),
  .COL_LO   (PROG_COL),
  .COL_HI   (PSI_COL + 1)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .capture_en (capture_en),
  .line_num   (line_num),
  .line_end   (line_end),
  .take       (take),
  .wr_fire    (wr_fire),
  .mem_we     (mem_we),
  .mem_row    (mem_row),
  .mem_col    (mem_col)
);

// File: tb/sim_vps_row_packer.sv
module sim_vps_row_packer;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       capture_en = 1'b1;
  logic [8:0] line_num = 9'd16;
  logic       start_det = 1'b0;
  logic       line_end = 1'b0;
  logic       half_vld = 1'b0;
  logic       half_bit = 1'b0;
  logic       mem_we;
  logic [4:0] mem_row;
  logic [5:0] mem_col;
  logic [4:0] mem_data;

  vps_row_packer u0 (
    .clk(clk), .rst(rst), .capture_en(capture_en), .line_num(line_num),
    .start_det(start_det), .line_end(line_end), .half_vld(half_vld),
    .half_bit(half_bit), .mem_we(mem_we), .mem_row(mem_row),
    .mem_col(mem_col), .mem_data(mem_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail = 0;
  int wcount = 0;
  bit cmp_on = 0;
  bit done = 0;

  logic [4:0] img [0:63];
  bit         written [0:63];

  logic [7:0] wbuf [3:15];
  bit [127:0] err11;
  bit [127:0] err00;

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit     m_on = 0;
  bit     hq[$];
  bit     bq[$];
  bit     eq_[$];
  int     m_nb = 0;
  bit     exp_we = 0;
  int     exp_col = 0;
  int     exp_data = 0;

  function automatic int col_of(int w, int lo);
    if (w >= 11 && w <= 14) return 12 + 2 * (w - 11) + lo;
    if (w == 15) return 20 + lo;
    if (w == 4)  return 22 + lo;
    return -1;
  endfunction

  always @(posedge clk) begin
    exp_we = 0;
    if (rst) begin
      m_on = 0; hq.delete(); bq.delete(); eq_.delete(); m_nb = 0;
    end else if (line_end || (start_det && capture_en && line_num == 16)) begin
      m_on = !line_end;
      hq.delete(); bq.delete(); eq_.delete(); m_nb = 0;
    end else if (m_on && capture_en && line_num == 16 && half_vld && m_nb < 104) begin
      hq.push_back(half_bit);
      if (hq.size() == 2) begin
        bq.push_back(hq[0] == 1 && hq[1] == 0);
        eq_.push_back(hq[0] == hq[1]);
        hq.delete();
        m_nb++;
        if (bq.size() == 4) begin
          int c;
          c = col_of(3 + (m_nb - 1) / 8, ((m_nb - 1) / 4) % 2);
          if (c >= 0) begin
            exp_we   = 1;
            exp_col  = c;
            exp_data = (int'(eq_[0] | eq_[1] | eq_[2] | eq_[3]) << 4) |
                       (int'(bq[0]) << 3) | (int'(bq[1]) << 2) |
                       (int'(bq[2]) << 1) | int'(bq[3]);
          end
          bq.delete(); eq_.delete();
        end
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (cmp_on) begin
      check(mem_we === exp_we, "R8 strobe", int'(mem_we), int'(exp_we));
      if (exp_we) begin
        check(mem_row == 5'd25, "R5 row", int'(mem_row), 25);
        check(int'(mem_col) == exp_col, "R6 column", int'(mem_col), exp_col);
        check(int'(mem_data) == exp_data, "R4 entry", int'(mem_data), exp_data);
      end
      if (mem_we === 1'b1) begin
        img[mem_col] = mem_data;
        written[mem_col] = 1;
        wcount++;
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(input bit hv, input bit hb, input bit sd, input bit le);
    @(negedge clk);
    half_vld = hv; half_bit = hb; start_det = sd; line_end = le;
  endtask

  task automatic send_line(input int nbits, input bit extra_half, input bit with_start);
    if (with_start) cyc(0, 0, 1, 0);
    for (int i = 0; i < nbits; i++) begin
      int  w;
      bit  b;
      w = 3 + i / 8;
      b = (w <= 15) ? wbuf[w][7 - (i % 8)] : 1'b1;
      if (err11[i])      begin cyc(1, 1, 0, 0); cyc(1, 1, 0, 0); end
      else if (err00[i]) begin cyc(1, 0, 0, 0); cyc(1, 0, 0, 0); end
      else               begin cyc(1, b, 0, 0); cyc(1, ~b, 0, 0); end
      if (i % 5 == 4) cyc(0, 0, 0, 0);
    end
    if (extra_half) cyc(1, 1, 0, 0);
    cyc(0, 0, 0, 1);
    cyc(0, 0, 0, 0);
    cyc(0, 0, 0, 0);
  endtask

  task automatic load_default();
    for (int k = 3; k <= 15; k++) wbuf[k] = 8'(k * 17 + 3);
    wbuf[4]  = 8'h3C;
    wbuf[11] = 8'hA5;
    wbuf[12] = 8'h96;
    wbuf[13] = 8'h0F;
    wbuf[14] = 8'hC3;
    wbuf[15] = 8'h81;
    err11 = '0;
    err00 = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int base;
    for (int k = 0; k < 64; k++) begin img[k] = 5'h00; written[k] = 0; end
    load_default();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    cmp_on = 1;
    @(negedge clk);
    // R11 reset state
    check(mem_we == 1'b0 && wcount == 0, "R11 reset state", int'(mem_we), 0);

    // R2 R6 R7: full line
    base = wcount;
    send_line(104, 0, 1);
    check(wcount - base == 12, "R7 write count", wcount - base, 12);
    check(img[12] == 5'h0A, "R2 word11 high", int'(img[12]), 'h0A);
    check(img[13] == 5'h05, "R6 word11 low", int'(img[13]), 'h05);
    check(img[18] == 5'h0C && img[19] == 5'h03, "R6 word14", int'({img[18], img[19]}), 'h183);
    check(img[20] == 5'h08 && img[21] == 5'h01, "R7 word15", int'({img[20], img[21]}), 'h101);
    check(img[22] == 5'h03 && img[23] == 5'h0C, "R7 word4", int'({img[22], img[23]}), 'h6C);
    begin
      int stray = 0;
      for (int k = 0; k < 64; k++) if (written[k] && (k < 12 || k > 23)) stray++;
      check(stray == 0, "R7 unmapped words", stray, 0);
    end

    // R1 wrong line
    line_num = 9'd17;
    base = wcount;
    send_line(104, 0, 1);
    check(wcount - base == 0, "R1 line 17 ignored", wcount - base, 0);
    line_num = 9'd16;

    // R1 capture disabled
    capture_en = 1'b0;
    base = wcount;
    send_line(104, 0, 1);
    check(wcount - base == 0, "R1 capture off", wcount - base, 0);
    capture_en = 1'b1;

    // R3 R4 error cells
    wbuf[12] = 8'hFF;
    wbuf[13] = 8'h01;
    err11[73] = 1;
    err00[87] = 1;
    send_line(104, 0, 1);
    check(img[14] == 5'h1B, "R3 11-cell nibble", int'(img[14]), 'h1B);
    check(img[15] == 5'h0F, "R4 clean nibble", int'(img[15]), 'h0F);
    check(img[17] == 5'h10, "R3 00-cell nibble", int'(img[17]), 'h10);
    load_default();

    // R9 truncated line then clean line
    base = wcount;
    send_line(22, 1, 1);
    check(wcount - base == 2, "R9 truncated line", wcount - base, 2);
    send_line(104, 0, 1);
    check(img[12] == 5'h0A, "R9 clean restart", int'(img[12]), 'h0A);

    // R12 overlong line
    base = wcount;
    send_line(120, 0, 1);
    check(wcount - base == 12, "R12 overlong line", wcount - base, 12);

    // R10 second reception overwrites raw
    wbuf[11] = 8'h5A;
    send_line(104, 0, 1);
    check(img[12] == 5'h05 && img[13] == 5'h0A, "R10 overwrite", int'({img[12], img[13]}), 'hAA);
    load_default();

    // R11 reset mid line, then halves without a start
    cyc(0, 0, 1, 0);
    for (int i = 0; i < 20; i++) cyc(1, i[0], 0, 0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    base = wcount;
    for (int i = 0; i < 80; i++) cyc(1, i[1], 0, 0);
    cyc(0, 0, 0, 1);
    cyc(0, 0, 0, 0);
    check(wcount - base == 0 && mem_we == 1'b0, "R11 reset mid line", wcount - base, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule